// File: doc/BRIEF.md
# Two-Coin Vending Controller with Change

This block is the credit keeper of a drink vending machine that sells one item for 2.5 currency units and accepts two kinds of coin: a half-unit coin and a whole-unit coin. All amounts inside the block are counted in half-units, so the item costs 5 and the coins are worth 1 and 2. Each clock cycle carries at most one coin event, qualified by a valid input.

The running credit lives in a one-hot Mealy state machine with one state per amount that can be held below the price (0, 0.5, 1.0, 1.5 and 2.0 units). When the coin of the current cycle brings the credit to or past the price, the block pulses its dispense output for one cycle, reports any overpayment as change in half-units, and drops the credit back to zero. Both outputs come from registers, so they appear one clock after the completing coin. Reset is synchronous and active low.

Top module: `vend_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, after that edge `vend_o` is 0, `change_o` is 0 and the credit is zero, so the next purchase needs a full 5 half-units.
- R2: With `coin_vld` high, code 1 adds one half-unit and code 2 adds two half-units to the credit; a coin that keeps the credit below 5 half-units gives `vend_o` = 0.
- R3: When credit plus the coin of a cycle reaches or passes 5 half-units, `vend_o` is 1 for the cycle after that clock edge.
- R4: With a dispense, `change_o` equals credit plus coin minus 5 in half-units: a whole coin on a credit of 4 gives 1, a half coin on 4 gives 0, an exact total gives 0.
- R5: The credit is zero right after a dispense, so the following purchase again needs 5 half-units.
- R6: A cycle with `coin_vld` low, or with a code of 0 or 3, leaves the credit unchanged and gives `vend_o` = 0 and `change_o` = 0 after that edge.
- R7: `vend_o` is never high in two cycles in a row, and `change_o` is 0 in every cycle where `vend_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| coin_vld | input | 1 | A coin event is present this cycle |
| coin_code | input | 2 | Coin value in half-units: 1 = half unit, 2 = whole unit, 0 and 3 ignored |
| vend_o | output | 1 | One-cycle pulse: release one item |
| change_o | output | 2 | Overpayment to return, in half-units, valid with `vend_o` |

## Verification
Every result of this block is due exactly one clock after the coin that causes it: the coin is driven on a falling edge, the design registers dispense and change on the next rising edge, and the bench samples both outputs on the falling edge that follows. The bench keeps its own credit count, updated after each sample, and derives the expected dispense and change from that count and the coin, so credit left by idle, invalid and reset cycles is checked through when the next purchase completes. Directed runs cover the exact total, both change cases at a credit of 2.0 and reset with credit pending; a seeded random run mixes valid, invalid and idle cycles.

// File: rtl/vend_pkg.sv
// Package: shared coin type for the vending controller.
// Assumes coin values are expressed in half-units.
package vend_pkg;

    // Decoded coin; the enum value equals its worth in half-units.
    typedef enum logic [1:0] {
        COIN_NONE  = 2'd0,
        COIN_HALF  = 2'd1,
        COIN_WHOLE = 2'd2
    } coin_e;

    // Worth of a decoded coin in half-units.
    function automatic int coin_halves(coin_e c);
        return int'(c);
    endfunction

endpackage

// File: rtl/vend_coin_decode.sv
// Module: vend_coin_decode
// Turns the raw coin code and its valid flag into a decoded coin.
// Assumes one coin event per cycle; unknown codes become "no coin".
module vend_coin_decode #(
    parameter int CODE_W     = 2,
    parameter int HALF_CODE  = 1,
    parameter int WHOLE_CODE = 2
) (
    input  logic              coin_vld,
    input  logic [CODE_W-1:0] coin_code,
    output vend_pkg::coin_e   coin
);
    import vend_pkg::*;

    // Purpose: map the qualified code onto the coin type.
    always_comb begin
        coin = COIN_NONE;
        if (coin_vld) begin
            if (coin_code == CODE_W'(HALF_CODE))
                coin = COIN_HALF;
            else if (coin_code == CODE_W'(WHOLE_CODE))
                coin = COIN_WHOLE;
        end
    end

endmodule

// File: rtl/vend_credit_fsm.sv
// Module: vend_credit_fsm
// One-hot credit state machine: state register and next-state logic.
// State i means i half-units inserted. Assumes PRICE >= 3 so that no
// single coin completes a purchase from zero. A state that is not one-hot
// returns to zero credit on the next clock.
module vend_credit_fsm #(
    parameter int PRICE = 5,
    localparam int CR_W = $clog2(PRICE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vend_pkg::coin_e  coin,
    output logic [PRICE-1:0] state_q,
    output logic [CR_W-1:0]  credit,
    output logic             legal
);
    import vend_pkg::*;

    logic [PRICE-1:0] state_d;
    int               sum;
    int               nxt;

    // Purpose: decode the one-hot state into a credit index.
    always_comb begin
        credit = '0;
        legal  = $onehot(state_q);
        for (int i = 0; i < PRICE; i++)
            if (state_q[i]) credit = CR_W'(i);
    end

    // Purpose: next state from current credit plus the arriving coin.
    always_comb begin
        sum = int'(credit) + coin_halves(coin);
        nxt = (sum >= PRICE) ? 0 : sum;
        if (!legal) nxt = 0;
        for (int i = 0; i < PRICE; i++)
            state_d[i] = (nxt == i);
    end

    // Purpose: state register, one change per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PRICE'(1);
        else        state_q <= state_d;
    end

    // R6: no coin leaves the credit where it was
    assert_credit_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (coin == COIN_NONE && legal) |=> $stable(state_q));

    // R5: reaching the price always returns to zero credit
    assert_zero_after_sale_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (legal && (int'(credit) + coin_halves(coin) >= PRICE)) |=> state_q[0]);

endmodule

// File: rtl/vend_out_reg.sv
// Module: vend_out_reg
// Registered Mealy outputs: dispense pulse and change, from the current
// credit and the arriving coin. Assumes credit is meaningful only when
// legal is high; an illegal state produces no sale.
module vend_out_reg #(
    parameter int PRICE = 5,
    parameter int CHG_W = 2,
    localparam int CR_W = $clog2(PRICE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  vend_pkg::coin_e  coin,
    input  logic [CR_W-1:0]  credit,
    input  logic             legal,
    output logic             vend_o,
    output logic [CHG_W-1:0] change_o
);
    import vend_pkg::*;

    logic             sale;
    logic [CHG_W-1:0] chg;
    int               sum;

    // Purpose: decide the sale and its change for this cycle.
    always_comb begin
        sum  = int'(credit) + coin_halves(coin);
        sale = legal && (sum >= PRICE);
        chg  = sale ? CHG_W'(sum - PRICE) : '0;
    end

    // Purpose: register the outputs one clock after the coin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vend_o   <= 1'b0;
            change_o <= '0;
        end else begin
            vend_o   <= sale;
            change_o <= chg;
        end
    end

    // R7: change only accompanies a dispense
    assert_change_with_vend_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (change_o != '0) |-> vend_o);

    // R7: dispense lasts a single cycle
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vend_o |=> !vend_o);

endmodule

// File: rtl/vend_ctrl.sv
// Module: vend_ctrl (top)
// Two-coin vending controller: half- and whole-unit coins, item price
// PRICE half-units, registered dispense pulse and change output.
// Assumes synchronous active-low reset and at most one coin per cycle.
module vend_ctrl #(
    parameter int PRICE      = 5,
    parameter int CODE_W     = 2,
    parameter int HALF_CODE  = 1,
    parameter int WHOLE_CODE = 2,
    parameter int CHG_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coin_vld,
    input  logic [CODE_W-1:0] coin_code,
    output logic              vend_o,
    output logic [CHG_W-1:0]  change_o
);
    import vend_pkg::*;

    localparam int CR_W = $clog2(PRICE);

    coin_e            coin;
    logic [PRICE-1:0] state_q;
    logic [CR_W-1:0]  credit;
    logic             legal;

    vend_coin_decode #(
        .CODE_W(CODE_W), .HALF_CODE(HALF_CODE), .WHOLE_CODE(WHOLE_CODE)
    ) u_dec (
        .coin_vld(coin_vld), .coin_code(coin_code), .coin(coin)
    );

    vend_credit_fsm #(.PRICE(PRICE)) u_fsm (
        .clk(clk), .rst_n(rst_n), .coin(coin),
        .state_q(state_q), .credit(credit), .legal(legal)
    );

    vend_out_reg #(.PRICE(PRICE), .CHG_W(CHG_W)) u_out (
        .clk(clk), .rst_n(rst_n), .coin(coin), .credit(credit), .legal(legal),
        .vend_o(vend_o), .change_o(change_o)
    );

    // R6: an idle cycle never causes a dispense
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !coin_vld |=> (!vend_o && change_o == '0));

    // R5: credit is zero while the dispense pulse is out
    assert_credit_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vend_o |-> state_q[0]);

endmodule

// File: tb/vend_ctrl_tb.sv
module vend_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PRICE      = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       coin_vld = 1'b0;
    logic [1:0] coin_code = 2'd0;
    logic       vend_o;
    logic [1:0] change_o;

    int tests = 0;
    int fails = 0;
    int model_credit = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vend_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .coin_vld(coin_vld), .coin_code(coin_code),
        .vend_o(vend_o), .change_o(change_o)
    );

    function automatic int coin_worth(logic vld, logic [1:0] code);
        if (!vld) return 0;
        if (code == 2'd1) return 1;
        if (code == 2'd2) return 2;
        return 0;
    endfunction

    function automatic int exp_vend(int cr, int w);
        return (cr + w >= PRICE) ? 1 : 0;
    endfunction

    function automatic int exp_change(int cr, int w);
        return (cr + w >= PRICE) ? cr + w - PRICE : 0;
    endfunction

    task automatic chk(string req, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    bit last_vend = 1'b0;

    // Drive one cycle at the falling edge, sample at the next falling edge.
    task automatic step(logic vld, logic [1:0] code);
        int w, ev, ec;
        coin_vld  = vld;
        coin_code = code;
        w  = coin_worth(vld, code);
        ev = exp_vend(model_credit, w);
        ec = exp_change(model_credit, w);
        @(posedge clk);
        @(negedge clk);
        if (w == 0) begin
            chk("R6 vend", int'(vend_o), 0);
            chk("R6 change", int'(change_o), 0);
        end else if (ev == 1) begin
            chk(last_vend ? "R5 vend" : "R3 vend", int'(vend_o), 1);
            chk("R4 change", int'(change_o), ec);
        end else begin
            chk(last_vend ? "R5 vend" : "R2 vend", int'(vend_o), 0);
            chk("R7 change", int'(change_o), 0);
        end
        model_credit = (ev == 1) ? 0 : model_credit + w;
        if (w != 0) last_vend = (ev == 1);
    endtask

    task automatic do_reset();
        coin_vld = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk("R1 vend", int'(vend_o), 0);
        chk("R1 change", int'(change_o), 0);
        rst_n = 1'b1;
        model_credit = 0;
        last_vend = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd2718));
        @(negedge clk);
        do_reset();
        // R2 / R3: five half coins, exact total
        for (int i = 0; i < 5; i++) step(1'b1, 2'd1);
        // R4: whole, whole, half -> exact, zero change
        step(1'b1, 2'd2); step(1'b1, 2'd2); step(1'b1, 2'd1);
        // R4: credit 2.0 then whole coin -> change 1
        step(1'b1, 2'd2); step(1'b1, 2'd2); step(1'b1, 2'd2);
        // R5: next purchase needs full price again
        step(1'b1, 2'd2); step(1'b1, 2'd2); step(1'b1, 2'd1);
        // R6: idle and invalid codes between coins keep the credit
        step(1'b1, 2'd1);
        step(1'b0, 2'd2);
        step(1'b1, 2'd3);
        step(1'b1, 2'd0);
        step(1'b1, 2'd2);
        step(1'b0, 2'd1);
        step(1'b1, 2'd1);
        step(1'b1, 2'd1);     // credit 2+... reaches 5 here (1+2+1+1)
        // R1: reset with credit pending clears it
        step(1'b1, 2'd2); step(1'b1, 2'd2);
        do_reset();
        step(1'b1, 2'd1);     // R1: only 1 now, no sale
        step(1'b1, 2'd2);
        step(1'b1, 2'd2);     // completes exactly
        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [1:0] c;
            v = ($urandom % 5) != 0;
            c = 2'($urandom % 4);
            step(v, c);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule